// File: doc/BRIEF.md
# Block-Marked FIFO with Reread and Rewrite

A single-clock first-in first-out buffer of 9-bit words with a power-of-two depth (512 or 1024). On top of the usual push and pop, the block keeps two saved positions: a read-side mark and a write-side mark. A load strobe stores the live pointer into its mark. A restore strobe puts the mark back into the live pointer. This lets a consumer read a block of data again after a fault, or lets a producer discard a partly written block and write it again.

Two protection switches move the boundaries that the flags use. With read protection on, the full boundary is measured from the read-side mark, so a block that may still be read again cannot be overwritten. With write protection on, the empty boundary is measured from the write-side mark, so words written after the mark stay hidden from the reader until the switch is cleared. The block drives empty, full, almost-empty and almost-full, and takes the two almost offsets as inputs. The read port falls through: `rd_data` always shows the oldest readable word.

Top module: `mark_fifo`

## Requirements
- R1: Words leave in the order they entered, and while `empty` is low `rd_data` shows the oldest readable word with no read latency.
- R2: A push while `full` is high and a pop while `empty` is high change neither pointer and no stored data.
- R3: With both protections off, `empty` is high only at 0 stored words and `full` is high only at DEPTH stored words.
- R4: `almost_empty` is high when the readable count is at most `ae_ofs`; `almost_full` is high when the writable-side count is at least DEPTH minus `af_ofs`, and low at one word fewer.
- R5: `rr_load` copies the read pointer into the read mark; `rr_restore` copies the read mark into the read pointer, so reading restarts at the marked word and the flags follow the restored count.
- R6: `rw_load` copies the write pointer into the write mark; `rw_restore` copies the write mark into the write pointer, discarding the words written since the mark.
- R7: A restore in the same cycle as a push or pop on the same side wins: the push or pop has no effect.
- R8: With `prot_rr` high, the full and almost-full count is the write pointer minus the read mark, so marked words are never overwritten.
- R9: With `prot_rw` high, the empty and almost-empty count is the write mark minus the read pointer.
- R10: After reset both pointers and both marks are zero: `empty` and `almost_empty` high, `full` and `almost_full` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push request |
| wr_data | input | W | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | W | Oldest readable word |
| rr_load | input | 1 | Store read pointer into read mark |
| rr_restore | input | 1 | Rewind read pointer to read mark |
| rw_load | input | 1 | Store write pointer into write mark |
| rw_restore | input | 1 | Rewind write pointer to write mark |
| prot_rr | input | 1 | Full boundary measured from read mark |
| prot_rw | input | 1 | Empty boundary measured from write mark |
| ae_ofs | input | log2(DEPTH)+1 | Almost-empty offset |
| af_ofs | input | log2(DEPTH)+1 | Almost-full offset |
| empty | output | 1 | No readable word |
| almost_empty | output | 1 | Readable count at or below `ae_ofs` |
| almost_full | output | 1 | Count at or above DEPTH minus `af_ofs` |
| full | output | 1 | Count equals DEPTH |

## Verification
The bench walks the fill level across every flag boundary, including the wrap of the pointers at DEPTH, so a design that compared only the address bits would call a full buffer empty, and an off-by-one in the almost-full compare shows up at DEPTH minus offset minus one. It rewinds both pointers and checks the restored data and flags, since a design that forgot to recompute the count after a restore would leave stale flags. It raises restore together with push or pop, where a design with the wrong priority would advance a pointer past the mark. It also turns on each protection and checks that a full buffer stays full after pops and that hidden words stay hidden, which a design ignoring the marks would get wrong by overwriting the block or exposing unfinished data.

// File: rtl/mark_fifo.sv
module mark_fifo #(
  parameter int DEPTH = 512,
  parameter int W = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  input  logic          rr_load,
  input  logic          rr_restore,
  input  logic          rw_load,
  input  logic          rw_restore,
  input  logic          prot_rr,
  input  logic          prot_rw,
  input  logic [PW-1:0] ae_ofs,
  input  logic [PW-1:0] af_ofs,
  output logic          empty,
  output logic          almost_empty,
  output logic          almost_full,
  output logic          full
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, rr_mark, rw_mark;
  logic [PW-1:0] rd_lim, wr_base, occ_rd, occ_wr;
  logic [PW:0]   af_level;
  logic          push, pop;

  assign rd_lim  = prot_rw ? rw_mark : wr_ptr;
  assign wr_base = prot_rr ? rr_mark : rd_ptr;
  assign occ_rd  = rd_lim - rd_ptr;
  assign occ_wr  = wr_ptr - wr_base;

  assign af_level     = (PW+1)'(DEPTH) - {1'b0, af_ofs};
  assign empty        = (occ_rd == '0);
  assign almost_empty = (occ_rd <= ae_ofs);
  assign full         = (occ_wr == PW'(DEPTH));
  assign almost_full  = ({1'b0, occ_wr} >= af_level);

  assign push = wr_en & ~full & ~rw_restore;
  assign pop  = rd_en & ~empty & ~rr_restore;

  assign rd_data = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rw_mark <= '0;
    end else begin
      if (rw_restore) wr_ptr <= rw_mark;
      else if (push)  wr_ptr <= wr_ptr + 1'b1;
      if (rw_load)    rw_mark <= wr_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      rr_mark <= '0;
    end else begin
      if (rr_restore) rd_ptr <= rr_mark;
      else if (pop)   rd_ptr <= rd_ptr + 1'b1;
      if (rr_load)    rr_mark <= rd_ptr;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rw_restore) |=> (wr_ptr == $past(wr_ptr))); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !rr_restore) |=> (rd_ptr == $past(rd_ptr))); // R2
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_rw |-> (occ_rd <= PW'(DEPTH))); // R3
  AST_REREAD_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    rr_restore |=> (rd_ptr == $past(rr_mark))); // R7
  AST_REWRITE_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    rw_restore |=> (wr_ptr == $past(rw_mark))); // R7
  AST_REREAD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    rr_load |=> (rr_mark == $past(rd_ptr))); // R5
  AST_REWRITE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    rw_load |=> (rw_mark == $past(wr_ptr))); // R6
  AST_FULL_IMPLIES_AF: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> almost_full); // R4

endmodule

// File: tb/mark_fifo_test.sv
module mark_fifo_test;
  localparam int DEPTH = 512;
  localparam int W = 9;
  localparam int PW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic rr_load = 1'b0, rr_restore = 1'b0, rw_load = 1'b0, rw_restore = 1'b0;
  logic prot_rr = 1'b0, prot_rw = 1'b0;
  logic [PW-1:0] ae_ofs = PW'(4), af_ofs = PW'(3);
  logic [W-1:0] rd_data;
  logic empty, almost_empty, almost_full, full;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mark_fifo #(.DEPTH(DEPTH), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rr_load(rr_load), .rr_restore(rr_restore),
    .rw_load(rw_load), .rw_restore(rw_restore), .prot_rr(prot_rr), .prot_rw(prot_rw),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .empty(empty), .almost_empty(almost_empty),
    .almost_full(almost_full), .full(full)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    prot_rr = 0; prot_rw = 0;
    rst_n = 0; tick; tick; rst_n = 1; tick;
  endtask

  task automatic push(input int v);
    wr_en = 1; wr_data = W'(v); tick; wr_en = 0;
  endtask

  task automatic pop;
    rd_en = 1; tick; rd_en = 0;
  endtask

  task automatic t_reset;
    do_reset;
    chk("R10 empty", empty, 1);
    chk("R10 almost_empty", almost_empty, 1);
    chk("R10 full", full, 0);
    chk("R10 almost_full", almost_full, 0);
  endtask

  task automatic t_order;
    do_reset;
    push(10); push(20); push(30);
    chk("R1 head0", rd_data, 10); pop;
    chk("R1 head1", rd_data, 20); pop;
    chk("R1 head2", rd_data, 30); pop;
    chk("R3 empty after drain", empty, 1);
  endtask

  task automatic t_levels_and_overflow;
    do_reset;
    for (int i = 1; i <= DEPTH; i++) begin
      push(i);
      if (i == 1)   chk("R3 not empty at 1", empty, 0);
      if (i == 4)   chk("R4 ae at ofs", almost_empty, 1);
      if (i == 5)   chk("R4 ae above ofs", almost_empty, 0);
      if (i == DEPTH-4) chk("R4 af at D-(m+1)", almost_full, 0);
      if (i == DEPTH-3) chk("R4 af at D-m", almost_full, 1);
      if (i == DEPTH-1) chk("R3 not full at D-1", full, 0);
    end
    chk("R3 full at D", full, 1);
    push(9'h1FF);
    chk("R2 still full", full, 1);
    for (int i = 1; i <= DEPTH; i++) begin
      chk("R2 R1 drain data", rd_data, i % 512);
      pop;
    end
    chk("R3 empty after full drain", empty, 1);
    pop;
    push(7);
    chk("R2 pop on empty ignored", rd_data, 7);
  endtask

  task automatic t_reread;
    do_reset;
    for (int i = 1; i <= 5; i++) push(100 + i);
    rr_load = 1; tick; rr_load = 0;
    pop; pop; pop;
    chk("R5 after pops", rd_data, 104);
    chk("R5 ae with 2 left", almost_empty, 1);
    rr_restore = 1; tick; rr_restore = 0;
    chk("R5 rewound head", rd_data, 101);
    chk("R5 ae recomputed", almost_empty, 0);
  endtask

  task automatic t_rewrite;
    do_reset;
    push(1); push(2);
    rw_load = 1; tick; rw_load = 0;
    push(50); push(51); push(52);
    rw_restore = 1; tick; rw_restore = 0;
    push(3);
    chk("R6 word0", rd_data, 1); pop;
    chk("R6 word1", rd_data, 2); pop;
    chk("R6 rewritten", rd_data, 3); pop;
    chk("R6 discarded", empty, 1);
  endtask

  task automatic t_priority;
    do_reset;
    push(11); push(12); push(13);
    rr_load = 1; tick; rr_load = 0;
    pop;
    chk("R7 popped once", rd_data, 12);
    rr_restore = 1; rd_en = 1; tick; rr_restore = 0; rd_en = 0;
    chk("R7 restore beats pop", rd_data, 11);
    rw_load = 1; tick; rw_load = 0;
    rw_restore = 1; wr_en = 1; wr_data = 99; tick; rw_restore = 0; wr_en = 0;
    pop; pop; pop;
    chk("R7 restore beats push", empty, 1);
  endtask

  task automatic t_prot_rr;
    do_reset;
    prot_rr = 1;
    rr_load = 1; tick; rr_load = 0;
    for (int i = 1; i <= DEPTH; i++) push(i);
    chk("R8 full", full, 1);
    pop; pop;
    chk("R8 full held by mark", full, 1);
    push(77);
    prot_rr = 0; #1;
    chk("R8 full released", full, 0);
    rr_restore = 1; tick; rr_restore = 0;
    chk("R8 block intact", rd_data, 1);
  endtask

  task automatic t_prot_rw;
    do_reset;
    prot_rw = 1;
    rw_load = 1; tick; rw_load = 0;
    push(5); push(6);
    chk("R9 hidden words", empty, 1);
    pop;
    prot_rw = 0; #1;
    chk("R9 visible", empty, 0);
    chk("R9 head", rd_data, 5);
  endtask

  initial begin
    t_reset;
    t_order;
    t_levels_and_overflow;
    t_reread;
    t_rewrite;
    t_priority;
    t_prot_rr;
    t_prot_rw;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule